// File: doc/BRIEF.md
# Overlay Data Memory Controller

This block sits between a DSP core's data memory port and its storage. The 14-bit data address space is split in two halves. The upper half is always served on chip. In that half, the topmost 32 words are a window of control registers and the words below them are RAM. The lower half is remapped by an overlay select register. It goes either to a second on-chip RAM or to one of two external banks, and those banks share a single external bus.

On-chip accesses finish in the cycle they are requested. An external access drives a 14-bit external address, in which the top bit names the bank. It holds a read or write strobe, and it keeps the core's ready low for a programmable number of wait cycles. The wait count comes from a 3-bit field. A mode bit either uses that field directly or stretches it to 2N+1.

The core holds its request, address, write enable and write data stable until it sees ready high at a rising edge. The access completes at that edge. Each on-chip RAM has 2^RAM_AW physical words and is indexed by the low RAM_AW address bits. A full-size build sets RAM_AW to 13.

Top module: `dmem_overlay_ctrl`

## Requirements
- R1: After reset the wait configuration register reads 0xFFFF and the overlay select register reads 0.
- R2: An access from 0x2000 to 0x3FDF goes to on-chip RAM. It completes with ready high in its first cycle and raises neither external strobe, and data written there reads back unchanged.
- R3: With overlay select 0, an access from 0x0000 to 0x1FFF goes to a separate on-chip RAM. It has zero wait cycles, and its contents stay independent of the upper-half RAM at the same low address bits.
- R4: With overlay select 1 or 2, a lower-half access is external. The external address carries the core address bits 12:0 in its bits 12:0, and bit 13 is driven 0 for select 1 and 1 for select 2. The external write data equals the core write data.
- R5: When bit 15 of the wait register is 0, an external access holds ready low for exactly N cycles, where N is the value in bits 14:12.
- R6: When bit 15 of the wait register is 1, an external access holds ready low for exactly 2N+1 cycles.
- R7: During an external access, the read strobe (for a read) or the write strobe (for a write) is high in every cycle of the access, and the other strobe stays low. For a read, the core read data equals the external input data in the final cycle, when ready is high.
- R8: The wait register sits at 0x3FFE and is read and written by the core. Bit 15 is the mode, bits 14:12 the data wait count, and bits 11:0 four 3-bit I/O wait fields, all stored and read back in full.
- R9: The overlay select register sits at 0x3FFF and holds bits 1:0. A write of the value 3 leaves it unchanged, and bits 15:2 read as zero.
- R10: Register-window addresses 0x3FE0 to 0x3FFD read as zero, and a write to them changes neither the wait register nor the overlay select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core access request, held until ready |
| core_addr | input | 14 | Core data address |
| core_we | input | 1 | 1 = write, 0 = read |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Read data, valid while ready is high |
| core_ready | output | 1 | Access completes at the rising edge where this is high |
| ext_addr | output | 14 | External address, bank bit at 13 |
| ext_din | input | 16 | External read data |
| ext_dout | output | 16 | External write data |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |

## Verification
The bench sweeps every mode bit and every wait count, for both external banks and both directions. Counting ready-low cycles therefore separates the direct count from the 2N+1 form at each N, including N=0, where the two forms give 0 and 1. The external input data is a function of the external address, so a wrong bank bit or a wrong low address shows up in the read data as well as on the address pins. The two on-chip halves are filled with different values at the same low address bits, which exposes any aliasing between them. The register window is probed with legal, illegal and unmapped writes.

// File: rtl/dmo_pkg.sv
package dmo_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 14;
    localparam int unsigned LOW_W  = ADDR_W - 1;
    localparam int unsigned WAIT_W = 5;

    localparam logic [ADDR_W-1:0] MMR_BASE  = 14'h3FE0;
    localparam logic [ADDR_W-1:0] WAIT_ADDR = 14'h3FFE;
    localparam logic [ADDR_W-1:0] OVL_ADDR  = 14'h3FFF;
    localparam logic [DATA_W-1:0] WAIT_RST  = 16'hFFFF;
    localparam logic [1:0]        OVL_BAD   = 2'd3;
    localparam logic [1:0]        OVL_BANK2 = 2'd2;

    typedef enum logic [1:0] {
        RG_LO_INT = 2'd0,
        RG_HI_INT = 2'd1,
        RG_MMR    = 2'd2,
        RG_EXT    = 2'd3
    } region_e;

    typedef struct packed {
        logic       mode;
        logic [2:0] dwait;
        logic [2:0] io3;
        logic [2:0] io2;
        logic [2:0] io1;
        logic [2:0] io0;
    } wait_cfg_t;

    typedef struct packed {
        region_e          rg;
        logic             bank2;
        logic [LOW_W-1:0] low;
    } decode_t;

    function automatic logic [WAIT_W-1:0] wait_cycles(input logic mode, input logic [2:0] n);
        return mode ? {1'b0, n, 1'b1} : {2'b00, n};
    endfunction
endpackage

// File: rtl/dmo_decode.sv
module dmo_decode
    import dmo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        ovl,
    output decode_t           dec
);
    always_comb begin
        dec.low   = addr[LOW_W-1:0];
        dec.bank2 = (ovl == OVL_BANK2);
        if (addr[ADDR_W-1]) begin
            dec.rg = (addr >= MMR_BASE) ? RG_MMR : RG_HI_INT;
        end else begin
            dec.rg = (ovl == 2'd0) ? RG_LO_INT : RG_EXT;
        end
    end
endmodule

// File: rtl/dmo_ram.sv
module dmo_ram #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dmo_regs.sv
module dmo_regs
    import dmo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output wait_cfg_t         wcfg,
    output logic [1:0]        ovl
);
    logic hit_wait, hit_ovl;

    assign hit_wait = (addr == WAIT_ADDR);
    assign hit_ovl  = (addr == OVL_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcfg <= wait_cfg_t'(WAIT_RST);
            ovl  <= 2'd0;
        end else if (sel && we) begin
            if (hit_wait) begin
                wcfg <= wait_cfg_t'(wdata);
            end
            if (hit_ovl && (wdata[1:0] != OVL_BAD)) begin
                ovl <= wdata[1:0];
            end
        end
    end

    always_comb begin
        if (hit_wait)     rdata = DATA_W'(wcfg);
        else if (hit_ovl) rdata = {{(DATA_W-2){1'b0}}, ovl};
        else              rdata = '0;
    end

    // R9: overlay select never holds the rejected code
    a_r9_ovl_legal: assert property (@(posedge clk) disable iff (rst) ovl != OVL_BAD);
    // R1: values right after reset release
    a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (DATA_W'(wcfg) == WAIT_RST && ovl == 2'd0));
    // R10: unmapped window writes leave both registers untouched
    a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (sel && we && !hit_wait && !hit_ovl) |=> ($stable(wcfg) && $stable(ovl)));
endmodule

// File: rtl/dmo_wait_seq.sv
module dmo_wait_seq
    import dmo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [WAIT_W-1:0] wait_n,
    output logic              ready
);
    logic [WAIT_W-1:0] cnt;
    logic              last;

    assign last  = (cnt == wait_n);
    assign ready = !active || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (active && !last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    // R5, R6: counter never runs past the programmed wait length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= wait_n));
    // R6: a nonzero count only follows an external cycle
    a_r6_cnt_origin: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> $past(active));
endmodule

// File: rtl/dmem_overlay_ctrl.sv
module dmem_overlay_ctrl
    import dmo_pkg::*;
#(
    parameter int unsigned RAM_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic [13:0]       core_addr,
    input  logic              core_we,
    input  logic [15:0]       core_wdata,
    output logic [15:0]       core_rdata,
    output logic              core_ready,
    output logic [13:0]       ext_addr,
    input  logic [15:0]       ext_din,
    output logic [15:0]       ext_dout,
    output logic              ext_rd,
    output logic              ext_wr
);
    localparam int unsigned NUM_RAM = 2;

    decode_t           dec;
    wait_cfg_t         wcfg;
    logic [1:0]        ovl;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] ram_rdata [NUM_RAM];
    logic              ext_act;
    logic [WAIT_W-1:0] wait_n;

    dmo_decode u_dec (
        .addr (core_addr),
        .ovl  (ovl),
        .dec  (dec)
    );

    dmo_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (core_req && dec.rg == RG_MMR),
        .we    (core_we),
        .addr  (core_addr),
        .wdata (core_wdata),
        .rdata (reg_rdata),
        .wcfg  (wcfg),
        .ovl   (ovl)
    );

    for (genvar gi = 0; gi < NUM_RAM; gi++) begin : g_ram
        localparam region_e MY_RG = (gi == 0) ? RG_LO_INT : RG_HI_INT;
        dmo_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
            .clk   (clk),
            .we    (core_req && core_we && dec.rg == MY_RG),
            .addr  (core_addr[RAM_AW-1:0]),
            .wdata (core_wdata),
            .rdata (ram_rdata[gi])
        );
    end

    assign ext_act = core_req && (dec.rg == RG_EXT);
    assign wait_n  = wait_cycles(wcfg.mode, wcfg.dwait);

    dmo_wait_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .active (ext_act),
        .wait_n (wait_n),
        .ready  (core_ready)
    );

    assign ext_addr = ext_act ? {dec.bank2, dec.low} : '0;
    assign ext_dout = core_wdata;
    assign ext_rd   = ext_act && !core_we;
    assign ext_wr   = ext_act && core_we;

    always_comb begin
        unique case (dec.rg)
            RG_LO_INT: core_rdata = ram_rdata[0];
            RG_HI_INT: core_rdata = ram_rdata[1];
            RG_MMR:    core_rdata = reg_rdata;
            default:   core_rdata = ext_din;
        endcase
    end

    // R7: at most one external strobe at a time
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_rd, ext_wr}));
    // R4: bank bit follows the overlay select
    a_r4_bank_bit: assert property (@(posedge clk) disable iff (rst)
        (ext_rd || ext_wr) |-> (ext_addr[13] == (ovl == OVL_BANK2)));
    // R2: upper half never waits and never touches the bus
    a_r2_upper_quiet: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_addr[13]) |-> (core_ready && !ext_rd && !ext_wr));
    // R7: an unfinished external read keeps its strobe next cycle while the core holds
    a_r7_strobe_hold: assert property (@(posedge clk) disable iff (rst)
        (ext_rd && !core_ready) |=> (ext_rd || !core_req));
endmodule

// File: tb/dmem_overlay_ctrl_bench.sv
module dmem_overlay_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_req = 1'b0;
    logic [13:0] core_addr = '0;
    logic        core_we = 1'b0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        core_ready;
    logic [13:0] ext_addr;
    logic [15:0] ext_din;
    logic [15:0] ext_dout;
    logic        ext_rd, ext_wr;

    int checks = 0;
    int fails  = 0;

    logic [15:0] t_rdata, t_edout;
    logic [13:0] t_eaddr;
    int          t_waits;
    logic        t_strobe_ok, t_any_strobe;

    always #2 clk = ~clk;

    assign ext_din = {2'b10, ext_addr} ^ 16'h5A3C;

    dmem_overlay_ctrl u_dmem_overlay_ctrl (
        .clk(clk), .rst(rst), .core_req(core_req), .core_addr(core_addr),
        .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_ready(core_ready), .ext_addr(ext_addr), .ext_din(ext_din),
        .ext_dout(ext_dout), .ext_rd(ext_rd), .ext_wr(ext_wr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [13:0] a, input logic w, input logic [15:0] d);
        int n = 0;
        @(negedge clk);
        core_req = 1'b1; core_addr = a; core_we = w; core_wdata = d;
        t_strobe_ok = 1'b1; t_any_strobe = 1'b0;
        forever begin
            #1;
            if (ext_rd || ext_wr) t_any_strobe = 1'b1;
            if (ext_rd != !w || ext_wr != w) t_strobe_ok = 1'b0;
            if (core_ready) begin
                t_rdata = core_rdata; t_eaddr = ext_addr; t_edout = ext_dout;
                break;
            end
            n++;
            @(negedge clk);
        end
        t_waits = n;
        @(negedge clk);
        core_req = 1'b0; core_we = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        acc(14'h3FFE, 1'b0, '0);
        chk(t_rdata == 16'hFFFF, "R1 wait reg reset", t_rdata, 16'hFFFF);
        acc(14'h3FFF, 1'b0, '0);
        chk(t_rdata == 16'h0000, "R1 overlay reset", t_rdata, 0);

        // R2 / R3: fill both on-chip halves with distinct data at the same low bits
        for (int i = 0; i < 16; i++) begin
            acc(14'h2000 + 14'(i * 7), 1'b1, 16'hC000 + 16'(i));
            chk(t_waits == 0 && !t_any_strobe, "R2 upper write no wait", t_waits, 0);
            acc(14'h0000 + 14'(i * 7), 1'b1, 16'h3000 + 16'(i * 3));
            chk(t_waits == 0 && !t_any_strobe, "R3 lower write no wait", t_waits, 0);
        end
        for (int i = 0; i < 16; i++) begin
            acc(14'h2000 + 14'(i * 7), 1'b0, '0);
            chk(t_rdata == 16'hC000 + 16'(i) && t_waits == 0, "R2 upper readback", t_rdata, 16'hC000 + 16'(i));
            acc(14'h0000 + 14'(i * 7), 1'b0, '0);
            chk(t_rdata == 16'h3000 + 16'(i * 3) && t_waits == 0, "R3 lower readback", t_rdata, 16'h3000 + 16'(i * 3));
        end

        // Sweep: mode x N x bank x direction
        for (int m = 0; m < 2; m++) begin
            for (int nn = 0; nn < 8; nn++) begin
                logic [15:0] wv;
                wv = {1'(m), 3'(nn), 12'(16'h9A5 + nn * 13)};
                acc(14'h3FFE, 1'b1, wv);
                acc(14'h3FFE, 1'b0, '0);
                chk(t_rdata == wv, "R8 wait reg readback", t_rdata, wv);
                for (int ov = 1; ov < 3; ov++) begin
                    acc(14'h3FFF, 1'b1, 16'(ov));
                    for (int w = 0; w < 2; w++) begin
                        logic [13:0] a, ea;
                        logic [15:0] d;
                        int expw;
                        a = 14'(((m * 8 + nn) * 37 + ov * 5 + w * 1000) & 16'h1FFF);
                        ea = {ov == 2, a[12:0]};
                        d = 16'h7E00 ^ 16'(a);
                        expw = (m == 1) ? 2 * nn + 1 : nn;
                        acc(a, 1'(w), d);
                        if (m == 0) chk(t_waits == expw, "R5 direct wait count", t_waits, expw);
                        else        chk(t_waits == expw, "R6 2N+1 wait count", t_waits, expw);
                        chk(t_eaddr == ea, "R4 external address", t_eaddr, ea);
                        chk(t_strobe_ok && t_any_strobe, "R7 strobe held", t_strobe_ok, 1);
                        if (w == 1) chk(t_edout == d, "R4 write data", t_edout, d);
                        else chk(t_rdata == ({2'b10, ea} ^ 16'h5A3C), "R7 read data", t_rdata, {2'b10, ea} ^ 16'h5A3C);
                    end
                end
            end
        end

        // R9 overlay register rules (currently 2)
        acc(14'h3FFF, 1'b1, 16'h0003);
        acc(14'h3FFF, 1'b0, '0);
        chk(t_rdata == 16'h0002, "R9 value 3 ignored", t_rdata, 2);
        acc(14'h3FFF, 1'b1, 16'hFFF1);
        acc(14'h3FFF, 1'b0, '0);
        chk(t_rdata == 16'h0001, "R9 upper bits read zero", t_rdata, 1);

        // R10 unmapped window
        acc(14'h3FFE, 1'b1, 16'h1234);
        acc(14'h3FE5, 1'b1, 16'hBEEF);
        acc(14'h3FE5, 1'b0, '0);
        chk(t_rdata == 16'h0000, "R10 unmapped reads zero", t_rdata, 0);
        acc(14'h3FE0, 1'b1, 16'h0000);
        acc(14'h3FFD, 1'b1, 16'h0002);
        acc(14'h3FFE, 1'b0, '0);
        chk(t_rdata == 16'h1234, "R10 wait reg untouched", t_rdata, 16'h1234);
        acc(14'h3FFF, 1'b0, '0);
        chk(t_rdata == 16'h0001, "R10 overlay untouched", t_rdata, 1);

        // R3: back to overlay 0, on-chip lower data survived the external sweep
        acc(14'h3FFF, 1'b1, 16'h0000);
        for (int i = 0; i < 16; i += 5) begin
            acc(14'h0000 + 14'(i * 7), 1'b0, '0);
            chk(t_rdata == 16'h3000 + 16'(i * 3) && !t_any_strobe, "R3 lower retained", t_rdata, 16'h3000 + 16'(i * 3));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule